// File: doc/BRIEF.md
# Asynchronous Strobe/Acknowledge Bus Master

This block drives a parallel bus that has no shared clock: a 16-bit address, 32-bit data carried in both directions, a read-not-write line, one common strobe that marks address and data as valid, and an acknowledge returned by a target that runs on its own clock. The local side issues one read or one write at a time through a request port. The block then runs the full four-phase handshake and reports completion with a one-cycle `done` pulse. For a read, `done` comes with the captured data.

The acknowledge passes through a chain of `SYNC_STAGES` flip-flops before the state machine uses it. Each of the two acknowledge edges therefore costs `SYNC_STAGES` extra cycles. With the default of two stages, a transfer against an instantly responding target takes eight cycles instead of four. The data pins are modelled as three signals: `bus_din`, `bus_dout` and the enable `bus_doe`. A timeout of `TIMEOUT_CYC` cycles guards both waits, so a missing or stuck acknowledge cannot hang the master. The master then ends the transfer and flags an error.

The state machine has four states:
- `ST_IDLE` goes to `ST_SETUP` on an accepted request.
- `ST_SETUP` goes to `ST_STROBE` unconditionally, after one cycle of address phase.
- `ST_STROBE` goes to `ST_RELEASE` when the synchronised acknowledge is high, or when the timeout expires.
- `ST_RELEASE` goes to `ST_IDLE` when the synchronised acknowledge is low, or when the timeout expires.

Top module: `hsbus_master`

## Requirements
- R1: While reset is active and after its release with no request, `busy`, `done`, `err`, `bus_strobe` and `bus_doe` are 0 and `rd_data` is 0.
- R2: A request is accepted only in `ST_IDLE`. `busy` is 1 from the cycle after acceptance until the cycle in which `done` pulses. Requests presented while `busy` is 1 are ignored: the bus address is unchanged and no further transfer starts.
- R3: Address, read-not-write (1 = read) and write data are driven for one cycle with the strobe low (`ST_SETUP`) before the strobe rises. They stay stable while the strobe is high.
- R4: The acknowledge is synchronised through `SYNC_STAGES` flip-flops. Against a target that follows the strobe within half a cycle, `done` is seen after the 4+2·`SYNC_STAGES` rising edge, where the edge that accepts the request is edge 1 (edge 8 by default).
- R5: On a read, `bus_din` is captured in the cycle the synchronised acknowledge is first seen high. It is presented on `rd_data` from the `done` pulse onward. A write leaves `rd_data` unchanged.
- R6: `bus_doe` is 1 only while the strobe is high during a write, and `bus_dout` then carries the request's write data.
- R7: If the acknowledge does not rise, the strobe stays high for exactly `TIMEOUT_CYC` cycles. It is then dropped, and the transfer ends with `done` and `err` (`done` on edge `TIMEOUT_CYC`+3 when the acknowledge stays low).
- R8: After the strobe drops, the master waits for the acknowledge to go low. If the acknowledge stays high for `TIMEOUT_CYC` cycles in `ST_RELEASE`, the master returns to idle with `done` and `err`. A later transfer then completes normally.
- R9: `done` is a single-cycle pulse, and `err` is 1 only in a cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a transfer (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Handshake in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was a timeout |
| rd_data | output | 32 | Last read data |
| bus_addr | output | 16 | Bus address |
| bus_rnw | output | 1 | Bus direction, 1 = read |
| bus_strobe | output | 1 | Common strobe |
| bus_dout | output | 32 | Data driven to bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 32 | Data from bus |
| bus_ack | input | 1 | Target acknowledge, asynchronous |

## Verification
The hardest case to reach is the exit from `ST_RELEASE` on timeout. It needs an acknowledge that rises and then never falls. A target that works correctly never produces this. The bench holds the acknowledge high before the request, long enough for it to pass the synchronizer, so the strobe phase ends after one cycle and the release wait then expires. A transfer with a well-behaved target follows, to show that the master recovers. The missing-acknowledge timeout and a request presented during a transfer are produced with the same bench-side target, switched between its following, silent and stuck behaviours.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE
    } hs_state_t;
endpackage

// File: rtl/hsbus_ack_sync.sv
module hsbus_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hsbus_timer.sv
module hsbus_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hsbus_fsm.sv
module hsbus_fsm
    import hsbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic ack_s,
    input  logic tmo,
    output logic busy,
    output logic strobe,
    output logic accept,
    output logic capture,
    output logic tmr_run,
    output logic tmr_restart,
    output logic done,
    output logic err
);
    hs_state_t state, state_n;
    logic      err_lat;
    logic      leaving;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_n = ST_SETUP;
            ST_SETUP:   state_n = ST_STROBE;
            ST_STROBE:  if (ack_s || tmo) state_n = ST_RELEASE;
            ST_RELEASE: if (!ack_s || tmo) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // combinational outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        strobe      = (state == ST_STROBE);
        accept      = (state == ST_IDLE) && req_valid;
        capture     = (state == ST_STROBE) && ack_s;
        tmr_run     = (state == ST_STROBE) || (state == ST_RELEASE);
        tmr_restart = tmr_run && (state_n != state);
        leaving     = (state == ST_RELEASE) && (state_n == ST_IDLE);
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            err     <= 1'b0;
            err_lat <= 1'b0;
        end else begin
            done <= leaving;
            err  <= leaving && (err_lat || ack_s);
            if (accept) begin
                err_lat <= 1'b0;
            end else if ((state == ST_STROBE) && !ack_s && tmo) begin
                err_lat <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/hsbus_master.sv
module hsbus_master #(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rnw,
    output logic          bus_strobe,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_ack
);
    logic ack_s, tmo, accept, capture, tmr_run, tmr_restart;

    hsbus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(bus_ack), .sync_out(ack_s)
    );

    hsbus_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .restart(tmr_restart),
        .expired(tmo)
    );

    hsbus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ack_s(ack_s),
        .tmo(tmo), .busy(busy), .strobe(bus_strobe), .accept(accept),
        .capture(capture), .tmr_run(tmr_run), .tmr_restart(tmr_restart),
        .done(done), .err(err)
    );

    // request latch: holds the bus fields for the whole handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr <= '0;
            bus_rnw  <= 1'b1;
            bus_dout <= '0;
        end else if (accept) begin
            bus_addr <= req_addr;
            bus_rnw  <= !req_write;
            bus_dout <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture && bus_rnw) begin
            rd_data <= bus_din;
        end
    end

    assign bus_doe = bus_strobe && !bus_rnw;
endmodule

// File: rtl/hsbus_master_chk.sv
module hsbus_master_chk #(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int TIMEOUT_CYC = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          bus_strobe,
    input logic          bus_rnw,
    input logic          bus_doe,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_dout
);
    localparam int HW = $clog2(TIMEOUT_CYC + 2) + 1;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!bus_strobe) begin
            hi_cnt <= '0;
        end else if (hi_cnt <= HW'(TIMEOUT_CYC)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R6
    doe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (bus_strobe && !bus_rnw));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && $past(bus_strobe)) |->
            ($stable(bus_addr) && $stable(bus_rnw) && $stable(bus_dout)));

    // R3
    setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_strobe) |-> $past(busy));

    // R9
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R2
    idle_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= HW'(TIMEOUT_CYC));
endmodule

bind hsbus_master hsbus_master_chk #(
    .AW(AW), .DW(DW), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .bus_strobe(bus_strobe), .bus_rnw(bus_rnw), .bus_doe(bus_doe),
    .bus_addr(bus_addr), .bus_dout(bus_dout)
);

// File: tb/hsbus_master_test.sv
module hsbus_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;
    localparam int TMO  = 16;
    localparam int LAT  = 4 + 2 * SYNC;
    localparam int TLAT = TMO + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, err, bus_rnw, bus_strobe, bus_doe;
    logic [31:0] rd_data, bus_dout, bus_din;
    logic [15:0] bus_addr;
    logic        bus_ack = 1'b0;

    int compared = 0, mismatched = 0;
    int tgt_mode = 0;            // 0 follow strobe, 1 silent, 2 stuck high
    logic [15:0] seen_addr = '0;
    logic [31:0] seen_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsbus_master #(.SYNC_STAGES(SYNC), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
        .bus_strobe(bus_strobe), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_ack(bus_ack)
    );

    // target model
    assign bus_din = {bus_addr, ~bus_addr};
    always @(negedge clk) begin
        case (tgt_mode)
            0:       bus_ack <= bus_strobe;
            1:       bus_ack <= 1'b0;
            default: bus_ack <= 1'b1;
        endcase
        if (tgt_mode == 0 && bus_strobe && !bus_rnw) begin
            seen_addr <= bus_addr;
            seen_data <= bus_dout;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one transfer; checks per cycle, latency and error flag
    task automatic run_xfer(input bit wr, input logic [15:0] a, input logic [31:0] d,
                            input int exp_n, input bit exp_err, input bit interfere,
                            output int hi);
        int  n = 0;
        bit  fin = 0;
        bit  e = 0;
        hi = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!fin && n < 60) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 1) begin
                req_valid = interfere;
                if (interfere) begin
                    req_addr = ~a; req_write = !wr;
                end
                // R3 address phase before strobe
                chk(!bus_strobe && busy && bus_addr == a && bus_rnw == !wr,
                    "R3 setup", {bus_strobe, busy, bus_addr}, {2'b01, a});
            end
            if (n == 3) req_valid = 1'b0;
            if (bus_strobe) hi++;
            chk(bus_doe == (bus_strobe && wr), "R6 doe", bus_doe, bus_strobe && wr);
            if (bus_doe) chk(bus_dout == d, "R6 dout", bus_dout, d);
            if (busy) chk(bus_addr == a, "R2 addr held", bus_addr, a);
            if (done) begin
                fin = 1; e = err;
            end else begin
                chk(!err, "R9 err without done", err, 0);
            end
        end
        chk(n == exp_n, "R4/R7 latency", n, exp_n);
        chk(e == exp_err, "R7/R8 err", e, exp_err);
        chk(!busy, "R2 idle at done", busy, 0);
        @(negedge clk);
        chk(!done, "R9 done pulse", done, 0);
    endtask

    task automatic t_reset();
        #(CLK_PERIOD * 2);
        chk(!busy && !done && !err && !bus_strobe && !bus_doe && rd_data == 0,
            "R1 in reset", {busy, done, err, bus_strobe, bus_doe}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !bus_strobe && !bus_doe && rd_data == 0,
            "R1 after reset", {busy, done, err, bus_strobe, bus_doe}, 0);
    endtask

    task automatic t_write_basic();
        int hi;
        tgt_mode = 0;
        run_xfer(1'b1, 16'h1234, 32'hCAFE_F00D, LAT, 1'b0, 1'b0, hi);
        chk(seen_addr == 16'h1234 && seen_data == 32'hCAFE_F00D, "R6 target got write",
            {seen_addr, seen_data}, {16'h1234, 32'hCAFE_F00D});
    endtask

    task automatic t_read_basic();
        int hi;
        tgt_mode = 0;
        run_xfer(1'b0, 16'h00A5, 32'h0, LAT, 1'b0, 1'b0, hi);
        chk(rd_data == 32'h00A5_FF5A, "R5 read data", rd_data, 32'h00A5_FF5A);
    endtask

    task automatic t_write_keeps_rd();
        int hi;
        run_xfer(1'b1, 16'h7777, 32'h1111_2222, LAT, 1'b0, 1'b0, hi);
        chk(rd_data == 32'h00A5_FF5A, "R5 write keeps rd_data", rd_data, 32'h00A5_FF5A);
    endtask

    task automatic t_busy_ignore();
        int hi;
        run_xfer(1'b0, 16'h0F0F, 32'h0, LAT, 1'b0, 1'b1, hi);
        chk(rd_data == {16'h0F0F, 16'hF0F0}, "R2 read unaffected", rd_data,
            {16'h0F0F, 16'hF0F0});
        repeat (3) begin
            @(negedge clk);
            chk(!busy && !bus_strobe, "R2 no extra transfer", busy, 0);
        end
    endtask

    task automatic t_timeout();
        int hi;
        tgt_mode = 1;
        run_xfer(1'b1, 16'h4242, 32'hDEAD_BEEF, TLAT, 1'b1, 1'b0, hi);
        chk(hi == TMO, "R7 strobe high cycles", hi, TMO);
        tgt_mode = 0;
    endtask

    task automatic t_stuck_ack();
        int hi;
        tgt_mode = 2;
        repeat (4) @(negedge clk);
        run_xfer(1'b1, 16'h5150, 32'h0000_0001, TLAT, 1'b1, 1'b0, hi);
        chk(hi == 1, "R8 strobe short with early ack", hi, 1);
        tgt_mode = 0;
        repeat (4) @(negedge clk);
        run_xfer(1'b0, 16'h8001, 32'h0, LAT, 1'b0, 1'b0, hi);
        chk(rd_data == 32'h8001_7FFE, "R8 recovery read", rd_data, 32'h8001_7FFE);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        t_reset();
        t_write_basic();
        t_read_basic();
        t_write_keeps_rd();
        t_busy_ignore();
        t_timeout();
        t_stuck_ack();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule